// File: doc/BRIEF.md
# Multi-Channel Aligned PWM Generator

This block drives up to four pulse-width-modulated channels from one shared period counter. A two-bit alignment input selects left-aligned, right-aligned or center-aligned waveforms, and every channel follows the same alignment. Each channel has its own compare (duty) value, an enable bit and a polarity bit. Per channel the block presents the logical state (active or inactive), the pin level after polarity is applied, and an output-enable that is low whenever the channel is off, so that the pad is left at high impedance.

Software, or a neighbouring sequencer, writes the period, the duty values and a control word through a single-cycle write port. Period, duty and alignment are held in shadow registers and copied into the working set only when a period ends, so a waveform is never cut short by a mid-period update. Enable and polarity act at once. The counter advances only on cycles where the tick input is high, which leaves prescaling to logic upstream. Complementary outputs, dead time and fault shutdown belong to blocks downstream.

Top module: `pwm_align_gen`

## Requirements
- R1: After reset every channel is disabled (`pin_oe` = 0, `ch_active` = 0, `pin_level` = 0), the working and shadow period are `PER_RST` (default 8), all duty values are 0 and the alignment is left.
- R2: In left alignment (mode 0, and the unused code 3 behaves the same) a period lasts P ticks, with the tick index t running from 0 to P-1, and an enabled channel is active while t < D, where D is its duty.
- R3: In right alignment (mode 1) a period lasts P ticks and an enabled channel is active while t + D >= P, so it becomes inactive exactly at the end of the period.
- R4: In center alignment (mode 2) a period lasts 2P ticks. The counter goes up from 0 to P-1, holds P-1 for one more tick, then comes down to 0. An enabled channel is active while the count c meets c + D >= P, which gives a pulse of 2D ticks centered on the turn-around.
- R5: A duty of 0 keeps a channel inactive, and a duty of P or more keeps an enabled channel active, in every alignment.
- R6: The control word at address 1 holds the enable bits in wr_data[3:0] (bit i for channel i) and the polarity bits in wr_data[7:4]. `pin_level` equals `ch_active` when the polarity bit is 0 and its inverse when the polarity bit is 1. Both fields take effect in the cycle after the write.
- R7: A disabled channel has `pin_oe` = 0 and `ch_active` = 0, and `pin_level` sits at its inactive level, which equals its polarity bit.
- R8: The period (address 0), the duty values (address 2+i for channel i) and the `mode` input go into the working set only on the tick that ends a period. Until then the running waveform is unchanged.
- R9: On a cycle where `tick_en` is low, the counter and all outputs hold their values.
- R10: A period value of 0 is loaded as 1.
- R11: Writes to addresses 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Counter advance enable |
| mode | input | 2 | Alignment: 0 left, 1 right, 2 center, 3 left; sampled at the period end |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (3) | Register address |
| wr_data | input | CNT_W (16) | Register write data |
| ch_active | output | NUM_CH (4) | Logical active state per channel |
| pin_level | output | NUM_CH (4) | Pin level after polarity |
| pin_oe | output | NUM_CH (4) | Pad drive enable; 0 means high impedance |

## Verification
All three outputs are decoded combinationally from registered state. The result of the tick or write applied at one rising edge is therefore valid during the rest of that cycle, and the bench samples it at the following falling edge. An enable or polarity write shows in the cycle right after its edge. A shadowed period, duty or mode shows only in the cycle after the edge on which the final tick of the period is taken. The driver works out the expected outputs for each edge from a tick-index model of the period and queues them. The monitor takes one item from the queue per falling edge, so each expected value is compared in exactly the cycle it is due.

// File: rtl/pwm_align_pkg.sv
package pwm_align_pkg;
    typedef enum logic [1:0] {
        ALIGN_LEFT   = 2'd0,
        ALIGN_RIGHT  = 2'd1,
        ALIGN_CENTER = 2'd2,
        ALIGN_RSVD   = 2'd3
    } align_e;
endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
    import pwm_align_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int NUM_CH  = 4,
    parameter int ADDR_W  = 3,
    parameter int PER_RST = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [CNT_W-1:0]               wr_data,
    input  align_e                         mode_in,
    input  logic                           wrap,
    output logic [CNT_W-1:0]               per_act,
    output logic [NUM_CH-1:0][CNT_W-1:0]   duty_act,
    output align_e                         mode_act,
    output logic [NUM_CH-1:0]              ch_en,
    output logic [NUM_CH-1:0]              ch_pol
);
    localparam logic [ADDR_W-1:0] ADDR_PER  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_CTL  = ADDR_W'(1);
    localparam int                DUTY_BASE = 2;
    localparam logic [CNT_W-1:0]  PER_INIT  = CNT_W'(PER_RST);

    typedef struct packed {
        logic [CNT_W-1:0]             per_sh;
        logic [CNT_W-1:0]             per_act;
        logic [NUM_CH-1:0][CNT_W-1:0] duty_sh;
        logic [NUM_CH-1:0][CNT_W-1:0] duty_act;
        align_e                       mode_act;
        logic [NUM_CH-1:0]            en;
        logic [NUM_CH-1:0]            pol;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        // working set refresh at the period end, from the values shadowed before this edge
        if (wrap) begin
            regs_d.per_act  = (regs_q.per_sh == '0) ? CNT_W'(1) : regs_q.per_sh;
            regs_d.duty_act = regs_q.duty_sh;
            regs_d.mode_act = mode_in;
        end
        if (wr_en) begin
            if (wr_addr == ADDR_PER) begin
                regs_d.per_sh = wr_data;
            end
            if (wr_addr == ADDR_CTL) begin
                regs_d.en  = wr_data[NUM_CH-1:0];
                regs_d.pol = wr_data[2*NUM_CH-1:NUM_CH];
            end
            for (int i = 0; i < NUM_CH; i++) begin
                if (wr_addr == ADDR_W'(DUTY_BASE + i)) begin
                    regs_d.duty_sh[i] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q          <= '0;
            regs_q.per_sh   <= PER_INIT;
            regs_q.per_act  <= PER_INIT;
            regs_q.mode_act <= ALIGN_LEFT;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign per_act  = regs_q.per_act;
    assign duty_act = regs_q.duty_act;
    assign mode_act = regs_q.mode_act;
    assign ch_en    = regs_q.en;
    assign ch_pol   = regs_q.pol;

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> ($stable(regs_q.per_act) && $stable(regs_q.duty_act) && $stable(regs_q.mode_act))) // R8
        else $error("working set changed outside a period end");

    AST_PER_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (regs_q.per_act != '0)) // R10
        else $error("zero period reached the working set");
endmodule

// File: rtl/pwm_base_ctr.sv
module pwm_base_ctr
    import pwm_align_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  align_e           mode_act,
    input  logic [CNT_W-1:0] per_act,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             down;
    } ctr_t;

    ctr_t ctr_d, ctr_q;
    logic at_top;
    logic wrap_c;

    always_comb begin
        ctr_d  = ctr_q;
        wrap_c = 1'b0;
        at_top = (ctr_q.cnt == per_act - ONE);
        if (tick_en) begin
            if (mode_act == ALIGN_CENTER) begin
                if (!ctr_q.down) begin
                    if (at_top) ctr_d.down = 1'b1;
                    else        ctr_d.cnt  = ctr_q.cnt + ONE;
                end else if (ctr_q.cnt == '0) begin
                    wrap_c     = 1'b1;
                    ctr_d.down = 1'b0;
                end else begin
                    ctr_d.cnt = ctr_q.cnt - ONE;
                end
            end else if (at_top) begin
                wrap_c     = 1'b1;
                ctr_d.cnt  = '0;
                ctr_d.down = 1'b0;
            end else begin
                ctr_d.cnt = ctr_q.cnt + ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctr_q <= '0;
        else        ctr_q <= ctr_d;
    end

    assign cnt  = ctr_q.cnt;
    assign wrap = wrap_c;

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ctr_q.cnt < per_act) // R2
        else $error("count outside the period");

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> ($stable(ctr_q.cnt) && $stable(ctr_q.down))) // R9
        else $error("counter moved without a tick");

    AST_DOWN_ONLY_CENTER: assert property (@(posedge clk) disable iff (!rst_n)
        ctr_q.down |-> (mode_act == ALIGN_CENTER)) // R4
        else $error("down-count outside center alignment");
endmodule

// File: rtl/pwm_chan_cmp.sv
module pwm_chan_cmp
    import pwm_align_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             en,
    input  logic             pol,
    input  align_e           mode_act,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] per_act,
    input  logic [CNT_W-1:0] duty,
    output logic             active,
    output logic             level,
    output logic             oe
);
    logic [CNT_W:0] reach;
    logic           early_on;
    logic           late_on;
    logic           raw_on;

    always_comb begin
        reach    = {1'b0, cnt} + {1'b0, duty};
        early_on = (cnt < duty);
        late_on  = (reach >= {1'b0, per_act});
        unique case (mode_act)
            ALIGN_RIGHT, ALIGN_CENTER: raw_on = late_on;
            default:                   raw_on = early_on;
        endcase
        active = en & raw_on;
        level  = active ^ pol;
        oe     = en;
    end
endmodule

// File: rtl/pwm_align_gen.sv
module pwm_align_gen
    import pwm_align_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int NUM_CH  = 4,
    parameter int PER_RST = 8,
    parameter int ADDR_W  = $clog2(NUM_CH + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [1:0]        mode,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [NUM_CH-1:0] ch_active,
    output logic [NUM_CH-1:0] pin_level,
    output logic [NUM_CH-1:0] pin_oe
);
    logic [CNT_W-1:0]             per_act;
    logic [NUM_CH-1:0][CNT_W-1:0] duty_act;
    align_e                       mode_act;
    logic [NUM_CH-1:0]            ch_en;
    logic [NUM_CH-1:0]            ch_pol;
    logic [CNT_W-1:0]             cnt;
    logic                         wrap;

    pwm_cfg_regs #(
        .CNT_W(CNT_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .PER_RST(PER_RST)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .mode_in(align_e'(mode)), .wrap(wrap),
        .per_act(per_act), .duty_act(duty_act), .mode_act(mode_act),
        .ch_en(ch_en), .ch_pol(ch_pol)
    );

    pwm_base_ctr #(.CNT_W(CNT_W)) i_ctr (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode_act(mode_act),
        .per_act(per_act), .cnt(cnt), .wrap(wrap)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_chan_cmp #(.CNT_W(CNT_W)) i_cmp (
            .en(ch_en[g]), .pol(ch_pol[g]), .mode_act(mode_act), .cnt(cnt),
            .per_act(per_act), .duty(duty_act[g]),
            .active(ch_active[g]), .level(pin_level[g]), .oe(pin_oe[g])
        );

        AST_ZERO_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
            (duty_act[g] == '0) |-> !ch_active[g]) // R5
            else $error("zero duty channel active");

        AST_FULL_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_en[g] && (duty_act[g] >= per_act)) |-> ch_active[g]) // R5
            else $error("full duty channel inactive");

        AST_DIS_TRISTATE: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_en[g] |-> (!pin_oe[g] && !ch_active[g] && (pin_level[g] == ch_pol[g]))) // R7
            else $error("disabled channel drives or is active");
    end
endmodule

// File: tb/test_pwm_align_gen.sv
`timescale 1ns/1ps
module test_pwm_align_gen;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  ch_active, pin_level, pin_oe;

    pwm_align_gen i_pwm_align_gen (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode(mode),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ch_active(ch_active), .pin_level(pin_level), .pin_oe(pin_oe)
    );

    always #5 clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;
    string cur_tag = "R1";

    logic [11:0] q_exp[$];
    string       q_tag[$];

    int m_per_sh = 8, m_per = 8, m_mode = 0, m_t = 0;
    int m_duty_sh[NCH] = '{default: 0};
    int m_duty[NCH]    = '{default: 0};
    logic [3:0] m_en = '0, m_pol = '0;

    function automatic bit exp_on(int i);
        int p = m_per;
        int d = m_duty[i];
        int x;
        if (!m_en[i]) return 1'b0;
        if (m_mode == 2) begin
            x = (m_t < p) ? m_t : (2 * p - 1 - m_t);
            return (x + d >= p);
        end
        if (m_mode == 1) return (m_t + d >= p);
        return (m_t < d);
    endfunction

    task automatic cyc(input bit tk, input bit we = 0, input int adr = 0, input int dat = 0);
        int len;
        logic [3:0] ea;
        tick_en = tk;
        wr_en   = we;
        wr_addr = adr[2:0];
        wr_data = dat[15:0];
        @(posedge clk);
        #1;
        len = (m_mode == 2) ? 2 * m_per : m_per;
        if (tk) begin
            if (m_t == len - 1) begin
                m_t   = 0;
                m_per = (m_per_sh == 0) ? 1 : m_per_sh;
                for (int i = 0; i < NCH; i++) m_duty[i] = m_duty_sh[i];
                m_mode = (int'(mode) == 3) ? 0 : int'(mode);
            end else begin
                m_t++;
            end
        end
        if (we) begin
            if (adr == 0) m_per_sh = dat & 16'hFFFF;
            else if (adr == 1) begin
                m_en  = dat[3:0];
                m_pol = dat[7:4];
            end else if (adr >= 2 && adr < 2 + NCH) m_duty_sh[adr - 2] = dat & 16'hFFFF;
        end
        for (int i = 0; i < NCH; i++) ea[i] = exp_on(i);
        q_exp.push_back({ea, ea ^ m_pol, m_en});
        q_tag.push_back(cur_tag);
        wr_en = 1'b0;
    endtask

    task automatic run(input int n);
        for (int k = 0; k < n; k++) cyc(1'b1);
    endtask

    always @(negedge clk) begin
        if (q_exp.size() > 0) begin
            logic [11:0] e;
            string tg;
            e  = q_exp.pop_front();
            tg = q_tag.pop_front();
            n_vec++;
            if ({ch_active, pin_level, pin_oe} !== e) begin
                n_bad++;
                $display("FAIL %s act/lvl/oe actual %b/%b/%b expected %b/%b/%b",
                         tg, ch_active, pin_level, pin_oe, e[11:8], e[7:4], e[3:0]);
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        cur_tag = "R1"; // reset state held with no ticks
        repeat (3) cyc(1'b0);

        cur_tag = "R6"; // enable all, channel 3 active low
        cyc(1'b0, 1'b1, 1, 16'h0080 | 16'h000F);
        cur_tag = "R8"; // duties shadowed only
        cyc(1'b1, 1'b1, 2, 2);
        cyc(1'b1, 1'b1, 3, 5);
        cyc(1'b1, 1'b1, 4, 0);
        cyc(1'b1, 1'b1, 5, 8);
        run(2);

        cur_tag = "R2"; // left alignment, includes the R5 corners on ch2 and ch3
        run(26);

        cur_tag = "R9"; // ticks with gaps
        for (int k = 0; k < 6; k++) begin cyc(1'b0); cyc(1'b1); end

        cur_tag = "R3"; mode = 2'd1;
        run(28);

        cur_tag = "R4"; mode = 2'd2;
        run(40);

        cur_tag = "R8"; // period change in the middle of a center period
        cyc(1'b1, 1'b1, 0, 5);
        cyc(1'b1, 1'b1, 3, 3);
        run(30);

        cur_tag = "R5"; // full-duty and zero-duty corners in center alignment
        run(12);

        cur_tag = "R11"; // unmapped addresses
        cyc(1'b1, 1'b1, 6, 16'hFFFF);
        cyc(1'b1, 1'b1, 7, 16'hFFFF);
        run(14);

        cur_tag = "R7"; // disable ch1, flip polarity of ch0 and ch3
        cyc(1'b1, 1'b1, 1, 16'h001D);
        run(12);

        cur_tag = "R10"; mode = 2'd0;
        cyc(1'b1, 1'b1, 0, 0);
        run(16);

        cur_tag = "R2"; mode = 2'd3; // unused code behaves as left
        cyc(1'b1, 1'b1, 0, 6);
        cyc(1'b1, 1'b1, 1, 16'h000F);
        run(20);

        cur_tag = "R9";
        repeat (4) cyc(1'b0);

        @(negedge clk);
        #1;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule